// File: doc/BRIEF.md
# Shadowed Auxiliary PWM Generator

A pulse-width modulator built around a free-running timestamp counter. The counter is compared with an active period value and an active compare value, both counted in input clock cycles. The output is asserted while the counter is below the compare value. A polarity bit can invert that relationship, and a mode bit forces the output low whenever PWM operation is off.

Software has two ways to change the waveform. While the counter is stopped, it writes the active period and compare values directly. While the counter is running, it writes a second, shadow pair instead. The block copies the shadow pair into the active pair on the clock edge that ends a period, so the period in progress always finishes with the values it started with. A small register port gives write access and combinational read access to the control word, the four value registers and the counter.

Top module: `shadow_pwm`

## Requirements
- R1: After reset the output is low, the counter is 0, and every readable register returns 0.
- R2: Register map by address: 0 control, 1 active period, 2 active compare, 3 shadow period, 4 shadow compare, 5 counter (read-only). A write lands on the next clock edge, and a read is combinational. In the control word, bit 4 is run, bits 7:6 are a stored sync field, bit 9 is PWM mode and bit 10 is polarity. All other control bits read 0.
- R3: While run is set, the counter increments on each edge. On the edge where it equals period-1 it returns to 0.
- R4: With mode set and polarity clear, the output is high exactly while the counter is less than the active compare value.
- R5: With mode set and polarity set, the output is the inverse of the R4 output, so the compare value sets the low time.
- R6: With mode clear, the output is low whatever the counter and registers hold.
- R7: While run is clear, the counter holds its value. Setting run again resumes counting from that value.
- R8: While running, the shadow period and shadow compare are copied into the active registers only on the period-end edge.
- R9: A shadow write on the same edge as a period-end transfer does not affect that transfer. It reaches the active registers at the following period end.
- R10: A compare value of 0 gives a permanently low output. A compare value at or above the period gives a permanently high output (normal polarity).
- R11: With an active period of 0 or 1, the counter stays at 0, and every running edge is a period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that a write to the active period while the block runs is an exceptional case. The transfer properties therefore exclude the edges that carry such a write. They also assume that software keeps the period at 1 or more whenever the shape of the waveform matters. The stimulus writes the active registers only while run is clear. While running, it changes values only through the shadow registers, and it uses a period of 0 or 1 only in the dedicated degenerate-period cases.

// File: rtl/shadow_pwm_pkg.sv
`timescale 1ns/1ps
package shadow_pwm_pkg;
  localparam int AW          = 3;
  localparam int NSLOT       = 2;  // period, compare
  localparam int BIT_RUN     = 4;
  localparam int BIT_SYNC_LO = 6;
  localparam int BIT_SYNC_HI = 7;
  localparam int BIT_MODE    = 9;
  localparam int BIT_POL     = 10;

  typedef enum logic [AW-1:0] {
    REG_CTRL = 3'd0,
    REG_PER  = 3'd1,
    REG_CMP  = 3'd2,
    REG_SPER = 3'd3,
    REG_SCMP = 3'd4,
    REG_CNT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/spwm_regs.sv
`timescale 1ns/1ps
module spwm_regs
  import shadow_pwm_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  period_end_i,
  output logic                  run_o,
  output logic                  mode_o,
  output logic                  pol_o,
  output logic [1:0]            sync_o,
  output logic [NSLOT*DW-1:0]   act_o,
  output logic [NSLOT*DW-1:0]   sh_o
);
  localparam int SYNC_W = BIT_SYNC_HI - BIT_SYNC_LO + 1;

  logic ctrl_we;
  assign ctrl_we = wr_en_i && (addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      mode_o <= 1'b0;
      pol_o  <= 1'b0;
      sync_o <= '0;
    end else if (ctrl_we) begin
      run_o  <= wdata_i[BIT_RUN];
      mode_o <= wdata_i[BIT_MODE];
      pol_o  <= wdata_i[BIT_POL];
      sync_o <= wdata_i[BIT_SYNC_LO +: SYNC_W];
    end
  end

  // one active/shadow pair per slot; a direct active write beats the transfer
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [DW-1:0] act_q, sh_q;
    logic act_we, sh_we;
    assign act_we = wr_en_i && (addr_i == AW'(int'(REG_PER) + g));
    assign sh_we  = wr_en_i && (addr_i == AW'(int'(REG_SPER) + g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q <= '0;
        sh_q  <= '0;
      end else begin
        if (act_we)            act_q <= wdata_i;
        else if (period_end_i) act_q <= sh_q;
        if (sh_we)             sh_q  <= wdata_i;
      end
    end

    assign act_o[g*DW +: DW] = act_q;
    assign sh_o[g*DW +: DW]  = sh_q;
  end
endmodule

// File: rtl/spwm_counter.sv
`timescale 1ns/1ps
module spwm_counter #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] per_i,
  output logic [DW-1:0] cnt_o,
  output logic          period_end_o
);
  logic [DW-1:0] cnt_q;

  // >= keeps a shrunken period from running the counter through full range
  assign period_end_o = run_i && ((per_i <= DW'(1)) || (cnt_q >= per_i - DW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (period_end_o) cnt_q <= '0;
    else if (run_i)        cnt_q <= cnt_q + DW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/spwm_out.sv
`timescale 1ns/1ps
module spwm_out #(
  parameter int DW = 32
) (
  input  logic          mode_i,
  input  logic          pol_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] cmp_i,
  output logic          pwm_o
);
  logic active_phase;
  assign active_phase = cnt_i < cmp_i;
  assign pwm_o        = mode_i & (active_phase ^ pol_i);
endmodule

// File: rtl/shadow_pwm.sv
`timescale 1ns/1ps
module shadow_pwm
  import shadow_pwm_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          pwm_o
);
  logic                run, mode, pol;
  logic [1:0]          sync;
  logic [NSLOT*DW-1:0] act_bus, sh_bus;
  logic [DW-1:0]       per_act, cmp_act, per_sh, cmp_sh, cnt;
  logic                period_end;
  logic [CW-1:0]       ctrl_rd;

  spwm_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .period_end_i (period_end),
    .run_o        (run),
    .mode_o       (mode),
    .pol_o        (pol),
    .sync_o       (sync),
    .act_o        (act_bus),
    .sh_o         (sh_bus)
  );

  assign per_act = act_bus[0  +: DW];
  assign cmp_act = act_bus[DW +: DW];
  assign per_sh  = sh_bus[0  +: DW];
  assign cmp_sh  = sh_bus[DW +: DW];

  spwm_counter #(.DW(DW)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .per_i        (per_act),
    .cnt_o        (cnt),
    .period_end_o (period_end)
  );

  spwm_out #(.DW(DW)) u_out (
    .mode_i (mode),
    .pol_i  (pol),
    .cnt_i  (cnt),
    .cmp_i  (cmp_act),
    .pwm_o  (pwm_o)
  );

  always_comb begin
    ctrl_rd                            = '0;
    ctrl_rd[BIT_RUN]                   = run;
    ctrl_rd[BIT_SYNC_HI:BIT_SYNC_LO]   = sync;
    ctrl_rd[BIT_MODE]                  = mode;
    ctrl_rd[BIT_POL]                   = pol;
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      REG_CTRL: rdata_o = DW'(ctrl_rd);
      REG_PER:  rdata_o = per_act;
      REG_CMP:  rdata_o = cmp_act;
      REG_SPER: rdata_o = per_sh;
      REG_SCMP: rdata_o = cmp_sh;
      REG_CNT:  rdata_o = cnt;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spwm_checker.sv
`timescale 1ns/1ps
module spwm_checker
  import shadow_pwm_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic          pwm_o,
  input logic          run,
  input logic          mode,
  input logic          pol,
  input logic          period_end,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] per_act,
  input logic [DW-1:0] cmp_act,
  input logic [DW-1:0] per_sh
);
  logic wr_per;
  assign wr_per = wr_en_i && (addr_i == REG_PER);

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && per_act > DW'(1) && cnt == per_act - DW'(1)) |=> (cnt == '0));

  p_mode_off_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode |-> !pwm_o);

  p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(cnt));

  p_xfer_per_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_end && !wr_per) |=> (per_act == $past(per_sh)));

  p_hold_per_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!period_end && !wr_per) |=> $stable(per_act));

  p_zero_duty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode && !pol && cmp_act == '0) |-> !pwm_o);

  p_short_period_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && per_act <= DW'(1)) |=> (cnt == '0));
endmodule

bind shadow_pwm spwm_checker #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .pwm_o      (pwm_o),
  .run        (run),
  .mode       (mode),
  .pol        (pol),
  .period_end (period_end),
  .cnt        (cnt),
  .per_act    (per_act),
  .cmp_act    (cmp_act),
  .per_sh     (per_sh)
);

// File: tb/shadow_pwm_bench.sv
`timescale 1ns/1ps
module shadow_pwm_bench;
  import shadow_pwm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  always #4 clk = ~clk;  // 125 MHz

  shadow_pwm u_shadow_pwm (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_o   (pwm)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_tag = "R4";

  // reference model built from the requirements
  logic [15:0] m_ctrl = '0;
  logic [31:0] m_per = '0, m_cmp = '0, m_sper = '0, m_scmp = '0, m_cnt = '0;

  function automatic logic m_pwm();
    return m_ctrl[9] & ((m_cnt < m_cmp) ^ m_ctrl[10]);
  endfunction

  function automatic logic m_last();
    return m_ctrl[4] && ((m_per <= 1) || (m_cnt >= m_per - 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic w, input logic [2:0] a, input logic [31:0] d);
    logic last;
    wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    last = m_last();
    if (m_ctrl[4]) m_cnt = last ? 32'd0 : m_cnt + 1;
    if (last) begin m_per = m_sper; m_cmp = m_scmp; end
    if (w) begin
      case (a)
        3'd0: m_ctrl = d[15:0] & 16'h06D0;
        3'd1: m_per  = d;
        3'd2: m_cmp  = d;
        3'd3: m_sper = d;
        3'd4: m_scmp = d;
        default: ;
      endcase
    end
    q.push_back('{m_pwm(), cur_tag});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 3'd0, 32'd0);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  // monitor: compare the output against the expected stream
  always @(negedge clk) begin
    item_t it;
    if (rst_n && q.size() > 0) begin
      it = q.pop_front();
      chk(pwm === it.exp, it.tag, {31'd0, pwm}, {31'd0, it.exp});
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R3 act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk(pwm === 1'b0, "R1", {31'd0, pwm}, 32'd0);
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 32'd0, "R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 control readback, R11 period 0
    cur_tag = "R11";
    tick(1, 3'd0, 32'h0000_FFFF);
    rd_chk(3'd0, 32'h0000_06D0, "R2");
    idle(3);
    rd_chk(3'd5, 32'd0, "R11");
    tick(1, 3'd0, 32'd0);
    tick(1, 3'd1, 32'd5);
    rd_chk(3'd1, 32'd5, "R2");
    tick(1, 3'd2, 32'd2);
    tick(1, 3'd3, 32'd5);
    tick(1, 3'd4, 32'd2);
    rd_chk(3'd3, 32'd5, "R2");
    rd_chk(3'd4, 32'd2, "R2");

    // R3/R4 normal run
    cur_tag = "R4";
    tick(1, 3'd0, 32'h210);
    idle(12);
    rd_chk(3'd5, m_cnt, "R3");
    idle(1);
    rd_chk(3'd5, m_cnt, "R3");

    cur_tag = "R5";
    tick(1, 3'd0, 32'h610);
    idle(6);

    cur_tag = "R6";
    tick(1, 3'd0, 32'h010);
    idle(6);
    chk(pwm === 1'b0, "R6", {31'd0, pwm}, 32'd0);

    // R7 freeze and resume
    cur_tag = "R7";
    tick(1, 3'd0, 32'h200);
    v = m_cnt;
    idle(4);
    rd_chk(3'd5, v, "R7");
    tick(1, 3'd0, 32'h210);
    idle(1);
    rd_chk(3'd5, (v == 32'd4) ? 32'd0 : v + 1, "R7");

    // R8 shadow transfer only at period end
    cur_tag = "R8";
    while (m_cnt != 32'd1) idle(1);
    tick(1, 3'd3, 32'd8);
    tick(1, 3'd4, 32'd6);
    rd_chk(3'd1, 32'd5, "R8");
    rd_chk(3'd2, 32'd2, "R8");
    while (m_cnt != 32'd0) idle(1);
    rd_chk(3'd1, 32'd8, "R8");
    rd_chk(3'd2, 32'd6, "R8");
    idle(10);

    // R9 shadow write on the transfer edge
    cur_tag = "R9";
    while (m_cnt != 32'd7) idle(1);
    tick(1, 3'd3, 32'd4);
    rd_chk(3'd1, 32'd8, "R9");
    rd_chk(3'd3, 32'd4, "R9");
    while (m_cnt != 32'd7) idle(1);
    idle(1);
    rd_chk(3'd1, 32'd4, "R9");

    // R10 compare >= period then compare 0
    cur_tag = "R10";
    idle(6);
    chk(pwm === 1'b1, "R10", {31'd0, pwm}, 32'd1);
    tick(1, 3'd4, 32'd0);
    while (m_cnt != 32'd0) idle(1);
    idle(6);
    chk(pwm === 1'b0, "R10", {31'd0, pwm}, 32'd0);

    // R11 period 1
    cur_tag = "R11";
    tick(1, 3'd0, 32'd0);
    tick(1, 3'd1, 32'd1);
    tick(1, 3'd3, 32'd1);
    tick(1, 3'd4, 32'd1);
    tick(1, 3'd0, 32'h210);
    idle(4);
    rd_chk(3'd5, 32'd0, "R11");
    rd_chk(3'd1, 32'd1, "R11");

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule